// File: doc/BRIEF.md
# DMA Channel Count and Reload Unit

This block follows the progress of one DMA channel and decides how the transfer ends. A start pulse loads a 4-bit block count, a 16-bit transfer count, a source address and a destination address. It also captures five configuration enables: count restore, source restore, destination restore, error interrupt and completion interrupt. Each accepted advance strobe stands for one data beat. The beat moves both addresses forward by the beat size and steps the two-level count. A transfer of block count B and transfer count T takes (B+1)*(T+1) beats.

A transfer can end in one of five ways: normal completion, address overflow, a stop (a peripheral stop request or a channel disable), a source access error, or a destination access error. The outcome is stored as a 3-bit status code. At the end, the counts, the source address and the destination address can each be restored to their start values, under independent enables. Two level interrupt requests, one for success and one for failure, are raised according to the captured enables. Both requests and the status are held until a clear pulse. The bus master, arbitration and data path are outside this block.

Top module: `dma_cnt_reload`

## Requirements
- R1: A start pulse with busy low and status 000 loads the four start values and sets busy in the next cycle. A start while busy, or while status is nonzero, changes nothing.
- R2: Each advance accepted while busy adds BEAT_BYTES (default 4) to both addresses. If the block count is nonzero it decrements. If the block count is zero it reloads to its start value and the transfer count decrements.
- R3: An advance accepted while both counts are zero ends the transfer with status 101 and clears busy. Without count restore both counts stay at zero.
- R4: With count restore captured at start, any transfer end puts both counts back to their start values.
- R5: With source restore captured at start, any transfer end puts the source address back to its start value, independently of the other restores.
- R6: With destination restore captured at start, any transfer end puts the destination address back to its start value, independently of the other restores.
- R7: Status codes are 000 while idle or busy, 001 for address overflow, 010 for a stop (peripheral stop or channel disable while busy), 011 for a source error and 100 for a destination error.
- R8: When several end conditions occur in the same cycle, priority runs source error, destination error, overflow, stop, success. A beat that ends with an error does not move the addresses or counts.
- R9: An advance whose increment carries out of bit 31 of either address ends with status 001. Both addresses keep their pre-beat values and the counts do not step.
- R10: err_irq rises at a transfer end with status 001 to 100 only if the error interrupt enable was captured as 1 at start.
- R11: done_irq rises at a transfer end with status 101 only if the completion interrupt enable was captured as 1 at start.
- R12: A clear pulse while not busy returns status to 000 and drops both interrupt requests in the next cycle. Enables are sampled only at an accepted start, and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| start_bc | input | 4 | Start block count |
| start_tc | input | 16 | Start transfer count |
| start_src | input | 32 | Start source address |
| start_dst | input | 32 | Start destination address |
| reload_cnt_en | input | 1 | Count restore enable, captured at start |
| reload_src_en | input | 1 | Source restore enable, captured at start |
| reload_dst_en | input | 1 | Destination restore enable, captured at start |
| err_irq_en | input | 1 | Error interrupt enable, captured at start |
| done_irq_en | input | 1 | Completion interrupt enable, captured at start |
| advance | input | 1 | One beat transferred |
| periph_stop | input | 1 | Peripheral stop request |
| chan_disable | input | 1 | Channel disabled |
| src_err | input | 1 | Source access error |
| dst_err | input | 1 | Destination access error |
| clr_status | input | 1 | Clears status and interrupt requests |
| cur_bc | output | 4 | Current block count |
| cur_tc | output | 16 | Current transfer count |
| cur_src | output | 32 | Current source address |
| cur_dst | output | 32 | Current destination address |
| busy | output | 1 | Transfer in progress |
| status | output | 3 | End status code |
| err_irq | output | 1 | Unsuccessful-end interrupt request |
| done_irq | output | 1 | Successful-end interrupt request |

## Verification
The hardest cases to reach from the ports are the end cycles where several conditions coincide. Examples are an overflow in the same cycle as a stop, and errors arriving on the very beat that would otherwise complete. The stimulus gets there by loading start addresses a few beats below the 32-bit limit and tiny counts. It then drives the competing inputs together on the chosen beat. The scoreboard predicts the restored or frozen counts and addresses, and confirms that the beat did not advance.

// File: rtl/dma_cr_pkg.sv
package dma_cr_pkg;

  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_OVF    = 3'd1,
    ST_STOP   = 3'd2,
    ST_SRCERR = 3'd3,
    ST_DSTERR = 3'd4,
    ST_DONE   = 3'd5
  } end_code_e;

  typedef struct packed {
    logic rl_cnt;
    logic rl_src;
    logic rl_dst;
    logic irq_err_en;
    logic irq_done_en;
  } chan_cfg_t;

endpackage

// File: rtl/dma_cr_count.sv
module dma_cr_count #(
  parameter int BC_W = 4,
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic            reload_i,
  input  logic [BC_W-1:0] bc_init_i,
  input  logic [TC_W-1:0] tc_init_i,
  output logic [BC_W-1:0] bc_o,
  output logic [TC_W-1:0] tc_o,
  output logic            last_o
);

  logic [BC_W-1:0] bc_q, bc_d, bc_sh_q, bc_sh_d;
  logic [TC_W-1:0] tc_q, tc_d, tc_sh_q, tc_sh_d;
  logic            en_w;

  assign last_o = (bc_q == '0) && (tc_q == '0);
  assign en_w   = load_i || step_i || reload_i;

  always_comb begin
    bc_d    = bc_q;
    tc_d    = tc_q;
    bc_sh_d = bc_sh_q;
    tc_sh_d = tc_sh_q;
    if (load_i) begin
      bc_d    = bc_init_i;
      tc_d    = tc_init_i;
      bc_sh_d = bc_init_i;
      tc_sh_d = tc_init_i;
    end else begin
      if (step_i && !last_o) begin
        if (bc_q == '0) begin
          bc_d = bc_sh_q;
          tc_d = tc_q - TC_W'(1);
        end else begin
          bc_d = bc_q - BC_W'(1);
        end
      end
      if (reload_i) begin
        bc_d = bc_sh_q;
        tc_d = tc_sh_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q    <= '0;
      tc_q    <= '0;
      bc_sh_q <= '0;
      tc_sh_q <= '0;
    end else if (en_w) begin
      bc_q    <= bc_d;
      tc_q    <= tc_d;
      bc_sh_q <= bc_sh_d;
      tc_sh_q <= tc_sh_d;
    end
  end

  assign bc_o = bc_q;
  assign tc_o = tc_q;

endmodule

// File: rtl/dma_cr_addr.sv
module dma_cr_addr #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          reload_i,
  input  logic [AW-1:0] init_i,
  output logic [AW-1:0] addr_o,
  output logic          carry_o
);

  localparam logic [AW:0] BEAT_EXT = (AW+1)'(BEAT_BYTES);

  logic [AW-1:0] addr_q, addr_d, sh_q, sh_d;
  logic [AW:0]   sum_w;
  logic          en_w;

  assign sum_w   = {1'b0, addr_q} + BEAT_EXT;
  assign carry_o = sum_w[AW];
  assign en_w    = load_i || step_i || reload_i;

  always_comb begin
    addr_d = addr_q;
    sh_d   = sh_q;
    if (load_i) begin
      addr_d = init_i;
      sh_d   = init_i;
    end else begin
      if (step_i) addr_d = sum_w[AW-1:0];
      if (reload_i) addr_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sh_q   <= '0;
    end else if (en_w) begin
      addr_q <= addr_d;
      sh_q   <= sh_d;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_cr_ctrl.sv
module dma_cr_ctrl
  import dma_cr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  chan_cfg_t cfg_i,
  input  logic      advance_i,
  input  logic      periph_stop_i,
  input  logic      chan_disable_i,
  input  logic      src_err_i,
  input  logic      dst_err_i,
  input  logic      clr_i,
  input  logic      ovf_i,
  input  logic      last_i,
  output logic      load_o,
  output logic      step_o,
  output logic      rl_cnt_o,
  output logic      rl_src_o,
  output logic      rl_dst_o,
  output logic      busy_o,
  output logic [2:0] status_o,
  output logic      err_irq_o,
  output logic      done_irq_o
);

  logic      busy_q, busy_d;
  end_code_e st_q, st_d, code_w;
  chan_cfg_t cfg_q, cfg_d;
  logic      eirq_q, eirq_d, dirq_q, dirq_d;
  logic      start_ok_w, end_w;

  always_comb begin
    start_ok_w = start_i && !busy_q && (st_q == ST_NONE);
    if (!busy_q)                            code_w = ST_NONE;
    else if (src_err_i)                     code_w = ST_SRCERR;
    else if (dst_err_i)                     code_w = ST_DSTERR;
    else if (advance_i && ovf_i)            code_w = ST_OVF;
    else if (periph_stop_i || chan_disable_i) code_w = ST_STOP;
    else if (advance_i && last_i)           code_w = ST_DONE;
    else                                    code_w = ST_NONE;
    end_w = (code_w != ST_NONE);
  end

  assign load_o   = start_ok_w;
  assign step_o   = busy_q && advance_i && ((code_w == ST_NONE) || (code_w == ST_DONE));
  assign rl_cnt_o = end_w && cfg_q.rl_cnt;
  assign rl_src_o = end_w && cfg_q.rl_src;
  assign rl_dst_o = end_w && cfg_q.rl_dst;

  always_comb begin
    busy_d = busy_q;
    st_d   = st_q;
    cfg_d  = cfg_q;
    eirq_d = eirq_q;
    dirq_d = dirq_q;
    if (clr_i && !busy_q) begin
      st_d   = ST_NONE;
      eirq_d = 1'b0;
      dirq_d = 1'b0;
    end
    if (start_ok_w) begin
      busy_d = 1'b1;
      cfg_d  = cfg_i;
    end
    if (end_w) begin
      busy_d = 1'b0;
      st_d   = code_w;
      eirq_d = cfg_q.irq_err_en && (code_w != ST_DONE);
      dirq_d = cfg_q.irq_done_en && (code_w == ST_DONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      st_q   <= ST_NONE;
      cfg_q  <= '0;
      eirq_q <= 1'b0;
      dirq_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      eirq_q <= eirq_d;
      dirq_q <= dirq_d;
    end
  end

  assign busy_o     = busy_q;
  assign status_o   = st_q;
  assign err_irq_o  = eirq_q;
  assign done_irq_o = dirq_q;

endmodule

// File: rtl/dma_cnt_reload.sv
module dma_cnt_reload
  import dma_cr_pkg::*;
#(
  parameter int BC_W       = 4,
  parameter int TC_W       = 16,
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BC_W-1:0] start_bc,
  input  logic [TC_W-1:0] start_tc,
  input  logic [AW-1:0]   start_src,
  input  logic [AW-1:0]   start_dst,
  input  logic            reload_cnt_en,
  input  logic            reload_src_en,
  input  logic            reload_dst_en,
  input  logic            err_irq_en,
  input  logic            done_irq_en,
  input  logic            advance,
  input  logic            periph_stop,
  input  logic            chan_disable,
  input  logic            src_err,
  input  logic            dst_err,
  input  logic            clr_status,
  output logic [BC_W-1:0] cur_bc,
  output logic [TC_W-1:0] cur_tc,
  output logic [AW-1:0]   cur_src,
  output logic [AW-1:0]   cur_dst,
  output logic            busy,
  output logic [2:0]      status,
  output logic            err_irq,
  output logic            done_irq
);

  localparam int NPTR = 2;

  chan_cfg_t     cfg_w;
  logic          load_w, step_w, last_w;
  logic          rl_cnt_w, rl_src_w, rl_dst_w;
  logic [AW-1:0] init_w  [NPTR];
  logic [AW-1:0] addr_w  [NPTR];
  logic          rl_w    [NPTR];
  logic [NPTR-1:0] carry_w;

  assign cfg_w = '{rl_cnt: reload_cnt_en, rl_src: reload_src_en, rl_dst: reload_dst_en,
                   irq_err_en: err_irq_en, irq_done_en: done_irq_en};

  assign init_w[0] = start_src;
  assign init_w[1] = start_dst;
  assign rl_w[0]   = rl_src_w;
  assign rl_w[1]   = rl_dst_w;

  dma_cr_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .cfg_i          (cfg_w),
    .advance_i      (advance),
    .periph_stop_i  (periph_stop),
    .chan_disable_i (chan_disable),
    .src_err_i      (src_err),
    .dst_err_i      (dst_err),
    .clr_i          (clr_status),
    .ovf_i          (|carry_w),
    .last_i         (last_w),
    .load_o         (load_w),
    .step_o         (step_w),
    .rl_cnt_o       (rl_cnt_w),
    .rl_src_o       (rl_src_w),
    .rl_dst_o       (rl_dst_w),
    .busy_o         (busy),
    .status_o       (status),
    .err_irq_o      (err_irq),
    .done_irq_o     (done_irq)
  );

  dma_cr_count #(.BC_W(BC_W), .TC_W(TC_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_w),
    .step_i    (step_w),
    .reload_i  (rl_cnt_w),
    .bc_init_i (start_bc),
    .tc_init_i (start_tc),
    .bc_o      (cur_bc),
    .tc_o      (cur_tc),
    .last_o    (last_w)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_cr_addr #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_w),
      .step_i   (step_w),
      .reload_i (rl_w[g]),
      .init_i   (init_w[g]),
      .addr_o   (addr_w[g]),
      .carry_o  (carry_w[g])
    );
  end

  assign cur_src = addr_w[0];
  assign cur_dst = addr_w[1];

endmodule

// File: rtl/dma_cr_chk.sv
module dma_cr_chk #(
  parameter int BC_W = 4,
  parameter int TC_W = 16,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_status,
  input logic [BC_W-1:0] cur_bc,
  input logic [TC_W-1:0] cur_tc,
  input logic [AW-1:0]   cur_src,
  input logic [AW-1:0]   cur_dst,
  input logic            busy,
  input logic [2:0]      status,
  input logic            err_irq,
  input logic            done_irq
);

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd5); // R7

  AST_BUSY_ZERO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == 3'd0)); // R7

  AST_NO_DUAL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_irq && done_irq)); // R10

  AST_DONE_IRQ_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (status == 3'd5)); // R11

  AST_ERR_IRQ_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ((status != 3'd0) && (status != 3'd5))); // R10

  AST_REFUSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (status != 3'd0) && !clr_status) |=>
      (!busy && $stable(cur_src) && $stable(cur_dst) && $stable(cur_bc) && $stable(cur_tc))); // R1

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && clr_status) |=> ((status == 3'd0) && !err_irq && !done_irq)); // R12

endmodule

bind dma_cnt_reload dma_cr_chk #(.BC_W(BC_W), .TC_W(TC_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_status (clr_status),
  .cur_bc     (cur_bc),
  .cur_tc     (cur_tc),
  .cur_src    (cur_src),
  .cur_dst    (cur_dst),
  .busy       (busy),
  .status     (status),
  .err_irq    (err_irq),
  .done_irq   (done_irq)
);

// File: tb/tb_dma_cnt_reload.sv
`timescale 1ns/1ps
module tb_dma_cnt_reload;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, advance, periph_stop, chan_disable, src_err, dst_err, clr_status;
  logic [3:0]  start_bc;
  logic [15:0] start_tc;
  logic [31:0] start_src, start_dst;
  logic        reload_cnt_en, reload_src_en, reload_dst_en, err_irq_en, done_irq_en;
  logic [3:0]  cur_bc;
  logic [15:0] cur_tc;
  logic [31:0] cur_src, cur_dst;
  logic        busy, err_irq, done_irq;
  logic [2:0]  status;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    string       tag;
    logic [3:0]  bc;
    logic [15:0] tc;
    logic [31:0] src;
    logic [31:0] dst;
    logic [2:0]  st;
    logic        ei;
    logic        di;
    logic        bsy;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  dma_cnt_reload dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bc(start_bc), .start_tc(start_tc),
    .start_src(start_src), .start_dst(start_dst), .reload_cnt_en(reload_cnt_en),
    .reload_src_en(reload_src_en), .reload_dst_en(reload_dst_en), .err_irq_en(err_irq_en),
    .done_irq_en(done_irq_en), .advance(advance), .periph_stop(periph_stop),
    .chan_disable(chan_disable), .src_err(src_err), .dst_err(dst_err),
    .clr_status(clr_status), .cur_bc(cur_bc), .cur_tc(cur_tc), .cur_src(cur_src),
    .cur_dst(cur_dst), .busy(busy), .status(status), .err_irq(err_irq), .done_irq(done_irq)
  );

  // Monitor: compares each expected item against the state after the next edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_tests++;
        if (cur_bc !== e.bc || cur_tc !== e.tc || cur_src !== e.src || cur_dst !== e.dst ||
            status !== e.st || err_irq !== e.ei || done_irq !== e.di || busy !== e.bsy) begin
          n_fail++;
          $display("FAIL %s: got bc=%0d tc=%0d src=%h dst=%h st=%0d ei=%0b di=%0b busy=%0b exp bc=%0d tc=%0d src=%h dst=%h st=%0d ei=%0b di=%0b busy=%0b",
                   e.tag, cur_bc, cur_tc, cur_src, cur_dst, status, err_irq, done_irq, busy,
                   e.bc, e.tc, e.src, e.dst, e.st, e.ei, e.di, e.bsy);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic expect_s(string tag, int bc, int tc, logic [31:0] src, logic [31:0] dst,
                          int st, bit ei, bit di, bit bsy);
    exp_t e;
    e.tag = tag; e.bc = 4'(bc); e.tc = 16'(tc); e.src = src; e.dst = dst;
    e.st = 3'(st); e.ei = ei; e.di = di; e.bsy = bsy;
    sb.push_back(e);
  endtask

  task automatic nxt();
    @(negedge clk);
    start = 0; advance = 0; periph_stop = 0; chan_disable = 0;
    src_err = 0; dst_err = 0; clr_status = 0;
  endtask

  task automatic go(int bc, int tc, logic [31:0] src, logic [31:0] dst,
                    bit rc, bit rs, bit rd, bit ee, bit de);
    start = 1; start_bc = 4'(bc); start_tc = 16'(tc); start_src = src; start_dst = dst;
    reload_cnt_en = rc; reload_src_en = rs; reload_dst_en = rd;
    err_irq_en = ee; done_irq_en = de;
  endtask

  initial begin
    rst_n = 0;
    start = 0; advance = 0; periph_stop = 0; chan_disable = 0;
    src_err = 0; dst_err = 0; clr_status = 0;
    start_bc = 0; start_tc = 0; start_src = 0; start_dst = 0;
    reload_cnt_en = 0; reload_src_en = 0; reload_dst_en = 0; err_irq_en = 0; done_irq_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_s("R12 reset state", 0, 0, 0, 0, 0, 0, 0, 0); nxt();

    // Plain transfer, 4 beats, completion irq enabled
    go(1, 1, 32'h100, 32'h2000, 0, 0, 0, 0, 1);
    expect_s("R1 start load", 1, 1, 32'h100, 32'h2000, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R2 beat1", 0, 1, 32'h104, 32'h2004, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R2 block wrap", 1, 0, 32'h108, 32'h2008, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R2 beat3", 0, 0, 32'h10C, 32'h200C, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R3 R11 success", 0, 0, 32'h110, 32'h2010, 5, 0, 1, 0); nxt();
    go(7, 7, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    expect_s("R1 start refused", 0, 0, 32'h110, 32'h2010, 5, 0, 1, 0); nxt();
    advance = 1; expect_s("R2 idle advance ignored", 0, 0, 32'h110, 32'h2010, 5, 0, 1, 0); nxt();
    clr_status = 1; expect_s("R12 clear", 0, 0, 32'h110, 32'h2010, 0, 0, 0, 0); nxt();

    // All restores, completion irq masked
    go(0, 1, 32'h40, 32'h80, 1, 1, 1, 1, 0);
    expect_s("R1 start2", 0, 1, 32'h40, 32'h80, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R2 zero block wrap", 0, 0, 32'h44, 32'h84, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R4 R5 R6 R11 restore all", 0, 1, 32'h40, 32'h80, 5, 0, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear2", 0, 1, 32'h40, 32'h80, 0, 0, 0, 0); nxt();

    // Source restore only, peripheral stop
    go(2, 0, 32'h10, 32'h20, 0, 1, 0, 1, 0);
    expect_s("R1 start3", 2, 0, 32'h10, 32'h20, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R2 beat", 1, 0, 32'h14, 32'h24, 0, 0, 0, 1); nxt();
    periph_stop = 1; expect_s("R5 R7 R10 stop src restore", 1, 0, 32'h10, 32'h24, 2, 1, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear3", 1, 0, 32'h10, 32'h24, 0, 0, 0, 0); nxt();

    // Destination restore only, channel disable, error irq masked
    go(3, 5, 32'h0, 32'h30, 0, 0, 1, 0, 0);
    expect_s("R1 start4", 3, 5, 32'h0, 32'h30, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R2 beat", 2, 5, 32'h4, 32'h34, 0, 0, 0, 1); nxt();
    chan_disable = 1; expect_s("R6 R7 R10 disable dst restore", 2, 5, 32'h4, 32'h30, 2, 0, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear4", 2, 5, 32'h4, 32'h30, 0, 0, 0, 0); nxt();

    // Priority: source error beats everything on the would-be last beat
    go(0, 0, 32'h8, 32'h8, 0, 0, 0, 1, 1);
    expect_s("R1 start5", 0, 0, 32'h8, 32'h8, 0, 0, 0, 1); nxt();
    advance = 1; src_err = 1; dst_err = 1; periph_stop = 1;
    expect_s("R8 src error wins", 0, 0, 32'h8, 32'h8, 3, 1, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear5", 0, 0, 32'h8, 32'h8, 0, 0, 0, 0); nxt();

    go(0, 0, 32'h8, 32'h8, 0, 0, 0, 1, 1);
    expect_s("R1 start6", 0, 0, 32'h8, 32'h8, 0, 0, 0, 1); nxt();
    advance = 1; dst_err = 1; chan_disable = 1;
    expect_s("R8 R7 dst error wins", 0, 0, 32'h8, 32'h8, 4, 1, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear6", 0, 0, 32'h8, 32'h8, 0, 0, 0, 0); nxt();

    // Source overflow in the same cycle as a stop, count restore
    go(2, 0, 32'hFFFF_FFF8, 32'h100, 1, 0, 0, 0, 0);
    expect_s("R1 start7", 2, 0, 32'hFFFF_FFF8, 32'h100, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R2 near top", 1, 0, 32'hFFFF_FFFC, 32'h104, 0, 0, 0, 1); nxt();
    advance = 1; periph_stop = 1;
    expect_s("R9 R8 R4 overflow over stop", 2, 0, 32'hFFFF_FFFC, 32'h104, 1, 0, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear7", 2, 0, 32'hFFFF_FFFC, 32'h104, 0, 0, 0, 0); nxt();

    // Destination overflow on first beat
    go(1, 0, 32'h500, 32'hFFFF_FFFC, 0, 0, 0, 1, 0);
    expect_s("R1 start8", 1, 0, 32'h500, 32'hFFFF_FFFC, 0, 0, 0, 1); nxt();
    advance = 1; expect_s("R9 R10 dst overflow", 1, 0, 32'h500, 32'hFFFF_FFFC, 1, 1, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear8", 1, 0, 32'h500, 32'hFFFF_FFFC, 0, 0, 0, 0); nxt();

    // Start and clear while busy are ignored; enables captured at start
    go(1, 2, 32'h0, 32'h0, 0, 0, 0, 1, 1);
    expect_s("R1 start9", 1, 2, 32'h0, 32'h0, 0, 0, 0, 1); nxt();
    go(5, 5, 32'h80, 32'h80, 1, 1, 1, 0, 0);
    expect_s("R1 start while busy", 1, 2, 32'h0, 32'h0, 0, 0, 0, 1); nxt();
    clr_status = 1; expect_s("R12 clear while busy", 1, 2, 32'h0, 32'h0, 0, 0, 0, 1); nxt();
    periph_stop = 1;
    expect_s("R12 R10 enables from start", 1, 2, 32'h0, 32'h0, 2, 1, 0, 0); nxt();
    clr_status = 1; expect_s("R12 clear9", 1, 2, 32'h0, 32'h0, 0, 0, 0, 0); nxt();

    go(0, 0, 32'h200, 32'h300, 0, 0, 0, 0, 0);
    expect_s("R1 start10", 0, 0, 32'h200, 32'h300, 0, 0, 0, 1); nxt();
    done_irq_en = 1; advance = 1;
    expect_s("R11 enable sampled at start", 0, 0, 32'h204, 32'h304, 5, 0, 0, 0); nxt();

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule